// File: doc/BRIEF.md
# Monotonic Write-Protection Register for an Emulated Non-Volatile Buffer

This block holds the write-protection setting for a buffer RAM that stands in for non-volatile storage. While reset is held, the register takes its whole value from a configuration byte. If the fault flag accompanies that byte, the register takes the most protective value instead. After reset, software may change the setting through a small register port, but only toward more protection. A write that would loosen any field is dropped for that field.

The register byte is split into four fields. Bit 7 is a global enable: 0 locks the whole buffer. Bits 6:4 are read-only and hold their reset value. Bit 3 disables range protection. Bits 2:0 give the size of the protected top region. The block compares each incoming buffer write address with the active setting and raises a blocked flag in the same cycle. The setting is always visible on the read data port.

Top module: `wprot_reg`

## Requirements
- R1: While rst_n is low, each rising clock edge loads the register with cfg_byte. After release, reg_rdata shows that byte.
- R2: If cfg_fault is 1 at the loading edge, the register loads 0x00.
- R3: Bits 6:4 ignore every write. They keep the value loaded during reset.
- R4: A write changes bit 7 only from 1 to 0. Writing 1 to bit 7 when it holds 0 leaves it at 0.
- R5: A write changes bit 3 only from 1 to 0. Writing 1 to bit 3 when it holds 0 leaves it at 0.
- R6: Bits 2:0 take the written value only if bit 3 held 1 before the write. Otherwise they keep their value.
- R7: One write may change several fields. Every field's rule is judged against the value held before that write.
- R8: When bit 7 is 0, chk_block equals chk_valid for every address.
- R9: When bit 7 is 1 and bit 3 is 1, chk_block is 0 for every address.
- R10: When bit 7 is 1 and bit 3 is 0, chk_block is 1 exactly for valid addresses at or above 1024 − (code+1)·64, where code is bits 2:0.
- R11: chk_block is 0 whenever chk_valid is 0.
- R12: reg_rdata shows the current register at all times. A write takes effect at the clock edge where reg_sel and reg_wr are both 1. reg_sel without reg_wr changes nothing.
- R13: Across any stream of writes after reset, the set of blocked addresses never shrinks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the register loads while it is low |
| cfg_byte | input | 8 | Configuration byte loaded during reset |
| cfg_fault | input | 1 | Marks the configuration byte as unreliable |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current protection setting |
| chk_valid | input | 1 | A buffer write address is presented |
| chk_addr | input | 10 | Buffer write byte address |
| chk_block | output | 1 | The presented write falls in a protected area |

## Verification
reg_rdata and chk_block are combinational from the held register and the present inputs. The bench therefore compares them with its model in the same cycle, a short delay after driving the inputs at the falling edge. A register write becomes visible only after the next rising edge. The model applies that write only after that edge, so the following cycle's comparison sees the new value and never an in-flight one. The reset load is checked on the first cycle after rst_n rises. Region size is recomputed from the model after every edge to confirm that it never decreases.

// File: rtl/wprot_reg.sv
module wprot_reg #(
  parameter int AW     = 10,
  parameter int BLK_SH = 6,
  parameter int SZW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg_byte,
  input  logic          cfg_fault,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          chk_valid,
  input  logic [AW-1:0] chk_addr,
  output logic          chk_block
);
  localparam int DEPTH = 1 << AW;

  logic           en_q, dis_q;
  logic [2:0]     rsv_q;
  logic [SZW-1:0] size_q;
  logic           wr_go;

  assign wr_go = reg_sel & reg_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= cfg_fault ? 1'b0 : cfg_byte[7];
      rsv_q  <= cfg_fault ? 3'b000 : cfg_byte[6:4];
      dis_q  <= cfg_fault ? 1'b0 : cfg_byte[3];
      size_q <= cfg_fault ? '0 : cfg_byte[SZW-1:0];
    end else if (wr_go) begin
      en_q  <= en_q & reg_wdata[7];
      dis_q <= dis_q & reg_wdata[3];
      if (dis_q) size_q <= reg_wdata[SZW-1:0];
    end
  end

  assign reg_rdata = {en_q, rsv_q, dis_q, size_q};

  logic [AW:0] span, base;
  logic        in_rng;

  assign span   = ((AW+1)'(size_q) + (AW+1)'(1)) << BLK_SH;
  assign base   = (AW+1)'(DEPTH) - span;
  assign in_rng = {1'b0, chk_addr} >= base;

  assign chk_block = chk_valid & (~en_q | (~dis_q & in_rng));
endmodule

// File: rtl/wprot_reg_chk.sv
module wprot_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_rdata,
  input logic       chk_valid,
  input logic       chk_block
);
  AST_RSV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(reg_rdata[6:4])); // R3
  AST_EN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !$rose(reg_rdata[7])); // R4
  AST_DIS_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !$rose(reg_rdata[3])); // R5
  AST_SIZE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(reg_rdata[3])) |-> $stable(reg_rdata[2:0])); // R6
  AST_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !reg_rdata[7]) |-> chk_block); // R8
  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && reg_rdata[3]) |-> !chk_block); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |-> !chk_block); // R11
endmodule

bind wprot_reg wprot_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata),
  .chk_valid(chk_valid), .chk_block(chk_block)
);

// File: tb/tb_wprot_reg.sv
`timescale 1ns/1ps
module tb_wprot_reg;
  logic clk = 0, rst_n = 0, cfg_fault = 0;
  logic [7:0] cfg_byte = 0, reg_wdata = 0, reg_rdata;
  logic reg_sel = 0, reg_wr = 0, chk_valid = 0, chk_block;
  logic [9:0] chk_addr = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wprot_reg dut (.clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .cfg_fault(cfg_fault),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_block(chk_block));

  int m_en, m_dis, m_size, m_rsv, prev_reg;

  function automatic int m_byte();
    return (m_en << 7) | (m_rsv << 4) | (m_dis << 3) | m_size;
  endfunction
  function automatic int m_region();
    if (m_en == 0) return 1024;
    if (m_dis == 1) return 0;
    return (m_size + 1) * 64;
  endfunction
  function automatic bit m_block(bit v, int a);
    if (!v) return 0;
    return a >= 1024 - m_region();
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic [7:0] cfg, bit flt, string tag);
    @(negedge clk);
    rst_n = 0; cfg_byte = cfg; cfg_fault = flt;
    reg_sel = 0; reg_wr = 0; chk_valid = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1; cfg_fault = 0;
    m_en = flt ? 0 : cfg[7]; m_rsv = flt ? 0 : cfg[6:4];
    m_dis = flt ? 0 : cfg[3]; m_size = flt ? 0 : cfg[2:0];
    prev_reg = m_region();
    #1 check(tag, reg_rdata, m_byte());
  endtask

  // drive at the falling edge, compare combinational outputs, model the rising edge
  task automatic step(bit sel, bit wr, logic [7:0] wd, bit cv, int ca, string tag);
    int o_en, o_dis;
    reg_sel = sel; reg_wr = wr; reg_wdata = wd; chk_valid = cv; chk_addr = 10'(ca);
    #1;
    check({tag, " rdata R12"}, reg_rdata, m_byte());
    check({tag, " block R8/R9/R10/R11"}, chk_block, m_block(cv, ca));
    @(posedge clk);
    if (sel && wr) begin
      o_en = m_en; o_dis = m_dis;
      m_en = o_en & wd[7];
      m_dis = o_dis & wd[3];
      if (o_dis == 1) m_size = wd[2:0];
    end
    if (m_region() < prev_reg) check("R13 region shrank", m_region(), prev_reg);
    prev_reg = m_region();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset(8'hFF, 0, "R1 reset load");
    step(0, 0, 0, 1, 1023, "R9 open");
    step(0, 0, 0, 0, 1023, "R11 idle");
    step(1, 0, 8'h00, 1, 5, "R12 sel no wr");
    step(1, 1, 8'h8A, 1, 0, "R6 size write");
    step(0, 0, 0, 1, 0, "R3 rsv kept");
    check("R3 rsv bits", reg_rdata[6:4], 3'b111);
    check("R6 size took", reg_rdata[2:0], 2);
    step(1, 1, 8'h85, 1, 1000, "R7 dis+size");
    check("R7 size with dis clear", reg_rdata, 8'hF5);
    step(0, 0, 0, 1, 640, "R10 base");
    step(0, 0, 0, 1, 639, "R10 below");
    step(1, 1, 8'h8F, 1, 1023, "R5 reset dis");
    check("R5 dis stays 0", reg_rdata[3], 0);
    check("R6 size frozen", reg_rdata[2:0], 5);
    step(1, 1, 8'h7F, 1, 0, "R4 clear en");
    step(0, 0, 0, 1, 0, "R8 locked");
    step(1, 1, 8'hFF, 1, 100, "R4 reset en");
    check("R4 en stays 0", reg_rdata[7], 0);
    step(0, 0, 0, 0, 100, "R11 locked idle");

    do_reset(8'hA3, 1, "R2 fault load");
    check("R2 fault value", reg_rdata, 8'h00);
    do_reset(8'h8F, 0, "R1 load 8F");
    step(1, 1, 8'h80, 1, 1023, "R10 min region");
    step(0, 0, 0, 1, 960, "R10 min base");
    step(0, 0, 0, 1, 959, "R10 min below");

    for (int r = 0; r < 20; r++) begin
      do_reset(8'($urandom), ($urandom % 8) == 0, "R1/R2 random load");
      for (int c = 0; c < 300; c++) begin
        logic [7:0] wd;
        wd = 8'($urandom);
        if ($urandom % 4 != 0) wd[7] = 1;
        if ($urandom % 4 != 0) wd[3] = 1;
        step(($urandom % 3) != 0, ($urandom % 3) != 0, wd,
             ($urandom % 5) != 0, int'($urandom % 1024), "R13 random");
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule